// File: doc/BRIEF.md
# Program Sequencer with One-Shot Indirect Execution

This block produces the fetch address for a 13-bit program space whose instructions are 16-bit words. It keeps two registers: a program counter that marks the sequential flow, and a fetch-address register that selects the word fetched next. Each clock cycle the block is given the operation decoded from the instruction that currently sits at the fetch address. It then updates both registers so that the fetch address points at the next instruction to run. The word fetch address is also provided as a byte address, which is the word address doubled.

Four operations are supported. A plain step advances the flow. A long jump goes to any 13-bit word. A conditional jump goes to a location inside the current 32-word page when a selected source field is non-zero. An indirect-execute operation runs exactly one instruction taken from a computed in-page location. To do this it redirects only the fetch-address register and leaves the program counter where it is. If that borrowed instruction does not itself redirect the flow, execution continues with the word that follows the indirect-execute instruction. Instruction decoding and the datapath that supplies the field value are outside this block.

Top module: `prog_sequencer`

## Requirements
- R1: `fetch_byte_o` always equals `fetch_word_o` shifted left by one bit, with a zero in bit 0.
- R2: Operation code 0 (step) sets the program counter to its old value plus one, modulo 8192. The fetch address takes that same value, so 0x1FFF is followed by 0x0000.
- R3: Operation code 1 (long jump) loads `target_i` into both the program counter and the fetch address.
- R4: Operation code 2 (conditional jump) is taken when the masked field is non-zero. A taken jump loads both registers with the upper 8 bits of the current program counter and `imm_i` in the low 5 bits. A jump that is not taken behaves like a step.
- R5: Operation code 3 (indirect execute) leaves the program counter unchanged. It sets the fetch address to the upper 8 bits of the current fetch address, with the low 5 bits of (masked field + `imm_i`) in the low 5 bits.
- R6: While `rst_n` is low, both the program counter and the fetch address are zero.
- R7: `field_i` is right-justified. A length code n from 1 to 7 keeps the low n bits of `field_i`. Length code 0 keeps all 8 bits. This rule applies to both the conditional jump and the indirect execute.
- R8: A step that follows an indirect execute resumes at the indirect-execute instruction's address plus one.
- R9: If the borrowed instruction is a long jump or a taken conditional jump, it overrides the return. A taken conditional jump in that slot builds its target from the page of the program counter, which is the indirect-execute instruction's page.
- R10: In the indirect-execute sum, any carry out of bit 4 is dropped, so the fetch address never leaves its 32-word page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | Operation of the current instruction: 0 step, 1 long jump, 2 conditional jump, 3 indirect execute |
| imm_i | input | 5 | In-page immediate |
| target_i | input | 13 | Long-jump target word address |
| field_i | input | 8 | Right-justified source field value |
| len_i | input | 3 | Field length code, where 0 means 8 bits |
| fetch_word_o | output | 13 | Word address of the next fetch |
| fetch_byte_o | output | 14 | Byte address of the next fetch |
| pc_o | output | 13 | Program counter |

## Verification
The assertions assume that `op_i`, `imm_i` and `target_i` are settled before each rising edge, and that they describe the instruction at the current fetch address. The bench drives every input on the falling edge and samples results on the following falling edge, so this assumption always holds. The field and length inputs are never checked by the properties, which only bound page and counter behaviour. Exact masked values are compared instead by the bench's arithmetic model, through full sweeps over every field value, every length code and immediates at both ends of the page.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;
    typedef enum logic [1:0] {
        OP_STEP   = 2'd0,
        OP_JUMP   = 2'd1,
        OP_NZJUMP = 2'd2,
        OP_EXEC1  = 2'd3
    } seq_op_e;
endpackage

// File: rtl/seq_field_mask.sv
// Keeps the low n bits of a right-justified field; length code 0 keeps all bits.
module seq_field_mask #(
    parameter int FIELD_W = 8,
    parameter int LEN_W   = 3,
    parameter int PAGE_W  = 5
) (
    input  logic [FIELD_W-1:0] field_i,
    input  logic [LEN_W-1:0]   len_i,
    output logic [PAGE_W-1:0]  low_o,
    output logic               nonzero_o
);
    logic [FIELD_W-1:0] keep;
    logic [FIELD_W-1:0] masked;

    for (genvar i = 0; i < FIELD_W; i++) begin : g_bit
        if (i < (1 << LEN_W)) begin : g_cmp
            assign keep[i] = (len_i == '0) || (LEN_W'(i) < len_i);
        end else begin : g_full
            assign keep[i] = (len_i == '0);
        end
    end

    assign masked    = field_i & keep;
    assign low_o     = masked[PAGE_W-1:0];
    assign nonzero_o = |masked;
endmodule

// File: rtl/seq_page_addr.sv
// Forms an in-page address: page bits kept, offset = (a + b) wrapped to the page.
module seq_page_addr #(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 5
) (
    input  logic [ADDR_W-PAGE_W-1:0] page_i,
    input  logic [PAGE_W-1:0]        off_a_i,
    input  logic [PAGE_W-1:0]        off_b_i,
    output logic [ADDR_W-1:0]        addr_o
);
    logic [PAGE_W-1:0] offset;

    assign offset = off_a_i + off_b_i;
    assign addr_o = {page_i, offset};
endmodule

// File: rtl/prog_sequencer.sv
module prog_sequencer #(
    parameter int ADDR_W  = 13,
    parameter int PAGE_W  = 5,
    parameter int FIELD_W = 8,
    parameter int LEN_W   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          op_i,
    input  logic [PAGE_W-1:0]   imm_i,
    input  logic [ADDR_W-1:0]   target_i,
    input  logic [FIELD_W-1:0]  field_i,
    input  logic [LEN_W-1:0]    len_i,
    output logic [ADDR_W-1:0]   fetch_word_o,
    output logic [ADDR_W:0]     fetch_byte_o,
    output logic [ADDR_W-1:0]   pc_o
);
    import prog_seq_pkg::*;

    localparam int HI_W = ADDR_W - PAGE_W;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] ar;
    } seq_state_t;

    seq_state_t        state_d, state_q;
    seq_op_e           op;
    logic [PAGE_W-1:0] fld_low;
    logic              fld_nz;
    logic [ADDR_W-1:0] pc_inc;
    logic [ADDR_W-1:0] nz_addr;
    logic [ADDR_W-1:0] exec_addr;

    assign op     = seq_op_e'(op_i);
    assign pc_inc = state_q.pc + 1'b1;

    seq_field_mask #(
        .FIELD_W(FIELD_W), .LEN_W(LEN_W), .PAGE_W(PAGE_W)
    ) u_mask (
        .field_i   (field_i),
        .len_i     (len_i),
        .low_o     (fld_low),
        .nonzero_o (fld_nz)
    );

    // conditional jump: page of the program counter, immediate offset
    seq_page_addr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_nz_addr (
        .page_i  (state_q.pc[ADDR_W-1:PAGE_W]),
        .off_a_i (imm_i),
        .off_b_i ('0),
        .addr_o  (nz_addr)
    );

    // indirect execute: page of the fetch address, field + immediate offset
    seq_page_addr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_exec_addr (
        .page_i  (state_q.ar[ADDR_W-1:ADDR_W-HI_W]),
        .off_a_i (fld_low),
        .off_b_i (imm_i),
        .addr_o  (exec_addr)
    );

    always_comb begin
        state_d = state_q;
        unique case (op)
            OP_STEP: begin
                state_d.pc = pc_inc;
                state_d.ar = pc_inc;
            end
            OP_JUMP: begin
                state_d.pc = target_i;
                state_d.ar = target_i;
            end
            OP_NZJUMP: begin
                state_d.pc = fld_nz ? nz_addr : pc_inc;
                state_d.ar = fld_nz ? nz_addr : pc_inc;
            end
            OP_EXEC1: begin
                state_d.ar = exec_addr;
            end
            default: begin
                state_d.pc = pc_inc;
                state_d.ar = pc_inc;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign fetch_word_o = state_q.ar;
    assign fetch_byte_o = {state_q.ar, 1'b0};
    assign pc_o         = state_q.pc;
endmodule

// File: rtl/prog_sequencer_chk.sv
module prog_sequencer_chk #(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        op_i,
    input logic [PAGE_W-1:0] imm_i,
    input logic [ADDR_W-1:0] target_i,
    input logic [ADDR_W-1:0] fetch_word_o,
    input logic [ADDR_W:0]   fetch_byte_o,
    input logic [ADDR_W-1:0] pc_o
);
    // R1
    a_r1_byte_addr: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_byte_o[ADDR_W:1] == fetch_word_o && fetch_byte_o[0] == 1'b0);

    // R2
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'd0) |=> (pc_o == ADDR_W'($past(pc_o) + 1'b1)) && (fetch_word_o == pc_o));

    // R3
    a_r3_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'd1) |=> (pc_o == $past(target_i)) && (fetch_word_o == $past(target_i)));

    // R4
    a_r4_nz_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'd2) |=> (fetch_word_o == pc_o) &&
            ((pc_o == ADDR_W'($past(pc_o) + 1'b1)) ||
             ((pc_o[ADDR_W-1:PAGE_W] == $past(pc_o[ADDR_W-1:PAGE_W])) &&
              (pc_o[PAGE_W-1:0] == $past(imm_i)))));

    // R5
    a_r5_pc_held: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'd3) |=> $stable(pc_o));

    // R10
    a_r10_same_page: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'd3) |=> fetch_word_o[ADDR_W-1:PAGE_W] == $past(fetch_word_o[ADDR_W-1:PAGE_W]));
endmodule

bind prog_sequencer prog_sequencer_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_i         (op_i),
    .imm_i        (imm_i),
    .target_i     (target_i),
    .fetch_word_o (fetch_word_o),
    .fetch_byte_o (fetch_byte_o),
    .pc_o         (pc_o)
);

// File: tb/sim_prog_sequencer.sv
`timescale 1ns/1ps
module sim_prog_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [4:0]  imm = '0;
    logic [12:0] tgt = '0;
    logic [7:0]  fld = '0;
    logic [2:0]  len = '0;
    logic [12:0] fetch_word;
    logic [13:0] fetch_byte;
    logic [12:0] pc;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;
    logic [12:0] m_pc = '0;
    logic [12:0] m_ar = '0;

    always #5 clk = ~clk;

    prog_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .op_i(op), .imm_i(imm), .target_i(tgt),
        .field_i(fld), .len_i(len), .fetch_word_o(fetch_word),
        .fetch_byte_o(fetch_byte), .pc_o(pc)
    );

    task automatic cmp(input int act, input int exp, input string req, input string what);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int masked(input logic [7:0] f, input logic [2:0] l);
        int n = (l == 0) ? 8 : int'(l);
        return int'(f) & ((1 << n) - 1);
    endfunction

    task automatic check_all(input string req);
        cmp(int'(pc), int'(m_pc), req, "pc");
        cmp(int'(fetch_word), int'(m_ar), req, "fetch");
        cmp(int'(fetch_byte), int'(m_ar) * 2, "R1", "byte");
    endtask

    // Drive at the falling edge, register at the rising edge, compare at the next falling edge.
    task automatic apply(input logic [1:0] o, input logic [4:0] i, input logic [12:0] t,
                         input logic [7:0] f, input logic [2:0] l, input string req);
        int mv;
        op = o; imm = i; tgt = t; fld = f; len = l;
        @(posedge clk);
        mv = masked(f, l);
        case (o)
            2'd0: begin m_pc = m_pc + 13'd1; m_ar = m_pc; end
            2'd1: begin m_pc = t; m_ar = t; end
            2'd2: begin
                if (mv != 0) m_pc = (m_pc & 13'h1FE0) | 13'(i);
                else         m_pc = m_pc + 13'd1;
                m_ar = m_pc;
            end
            default: m_ar = (m_ar & 13'h1FE0) | 13'((mv + int'(i)) & 31);
        endcase
        @(negedge clk);
        check_all(req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_all("R6");
        rst_n = 1'b1;

        // R2: step and wrap at the top of the space
        apply(2'd0, 0, 0, 0, 0, "R2");
        apply(2'd1, 0, 13'h1FFA, 0, 0, "R3");
        for (int k = 0; k < 10; k++) apply(2'd0, 0, 0, 0, 0, "R2");

        // R3: long jumps
        for (int k = 0; k < 32; k++) apply(2'd1, 0, 13'((k * 243 + 7) & 13'h1FFF), 0, 0, "R3");

        // R4, R7: conditional jump over every length code and field value
        for (int l = 0; l < 8; l++)
            for (int f = 0; f < 256; f++) begin
                apply(2'd1, 0, 13'((f * 37 + l * 512) & 13'h1FFF), 0, 0, "R3");
                apply(2'd2, 5'(f ^ l), 0, 8'(f), 3'(l), (l == 0) ? "R7" : "R4");
            end

        // R5, R7, R8, R10: indirect execute then return by a step
        for (int l = 0; l < 8; l++)
            for (int f = 0; f < 256; f++)
                for (int s = 0; s < 4; s++) begin
                    int ib = (s == 0) ? 0 : (s == 1) ? 9 : (s == 2) ? 22 : 31;
                    int base = (s == 3) ? 13'h1FFF : ((f * 53 + l * 700 + s) & 13'h1FFF);
                    apply(2'd1, 0, 13'(base), 0, 0, "R3");
                    apply(2'd3, 5'(ib), 0, 8'(f), 3'(l), (s == 3) ? "R10" : "R5");
                    apply(2'd0, 0, 0, 0, 0, "R8");
                end

        // R9: slot instruction overrides the return
        apply(2'd1, 0, 13'h0456, 0, 0, "R3");
        apply(2'd3, 5'd3, 0, 8'h05, 3'd3, "R5");
        apply(2'd1, 0, 13'h1234, 0, 0, "R9");
        apply(2'd1, 0, 13'h0A3E, 0, 0, "R3");
        apply(2'd3, 5'd4, 0, 8'h01, 3'd1, "R10");
        apply(2'd2, 5'd17, 0, 8'h80, 3'd0, "R9");
        apply(2'd1, 0, 13'h0C21, 0, 0, "R3");
        apply(2'd3, 5'd1, 0, 8'h00, 3'd0, "R5");
        apply(2'd2, 5'd17, 0, 8'hFE, 3'd1, "R9");
        apply(2'd1, 0, 13'h0300, 0, 0, "R3");
        apply(2'd3, 5'd8, 0, 8'h00, 3'd0, "R5");
        apply(2'd3, 5'd2, 0, 8'h40, 3'd0, "R5");
        apply(2'd0, 0, 0, 0, 0, "R8");

        // R6: reset in the middle of a run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        m_pc = '0; m_ar = '0;
        check_all("R6");
        @(negedge clk);
        rst_n = 1'b1;
        apply(2'd0, 0, 0, 0, 0, "R2");

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule